// File: doc/BRIEF.md
# Hierarchical Interrupt Latch Controller

This block collects interrupt events from up to 24 groups of eight inputs. Each implemented group keeps three byte-wide views: the live source levels, a sticky latch that records edges, and a mask. Groups can be read by a host through a small synchronous register port. A second level of summary bytes gives one bit per group. That bit is set while the group's latch holds any unmasked event. A handler therefore reads a summary byte, then the one latch it points at, and that read clears the latch.

The single active-high interrupt line is a registered OR of every summary bit. Selected groups can be configured so that they record falling edges of the group two positions below them. This lets a line with both edge events report through two latches. Groups may also be left out at elaboration; they then read as zero and ignore writes.

Top module: `hier_irq_ctrl`

## Requirements
- R1: After reset every implemented mask byte reads 0xFF, every latch and summary byte reads 0x00, and irq_out is 0.
- R2: Registers are decoded only when address bits [15:8] equal the bank 0x0E. Group n's source is at offset 0x00+n, its latch at 0x20+n and its mask at 0x40+n. Summary byte i is at offset 0x60+i. Reads in another bank return 0x00.
- R3: A 0-to-1 change of input bit k (group k/8, bit k%8) sets the latch bit. A level held high does not set it again after it is cleared, and the latch bit stays set until its latch byte is read.
- R4: A latch read returns the pending bits and clears them. An edge arriving in the same cycle as that read is kept for the next read.
- R5: A mask bit of 1 keeps its latch bit out of the summary and the interrupt, but the latch still records the edge. A mask bit of 0 lets it through. A mask write takes effect on the next cycle.
- R6: Summary bit b of byte i is 1 exactly while latch i*8+b has a bit set whose mask bit is 0. Reading a summary byte does not change any state.
- R7: irq_out rises on the second clock edge after the input edge, one cycle after the summary bit. It falls one cycle after the last unmasked pending bit is cleared.
- R8: In a falling-edge group (default groups 8 and 9), a 1-to-0 change of bit b of group n-2 sets latch bit b of group n. That group's own inputs are ignored, and its source byte shows group n-2's levels.
- R9: An unimplemented group (default group 5) reads 0x00 at all three offsets, ignores mask writes and never raises the summary or the interrupt.
- R10: Writes to source, latch and summary offsets change nothing.
- R11: Read data is registered: it appears the cycle after the read strobe. Offsets that decode to no register, including summary bytes beyond the configured count, read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_src | input | NUM_GROUPS*8 | Event inputs, bit k is group k/8 bit k%8 |
| host_addr | input | 16 | Bank in [15:8], register offset in [7:0] |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Active-high interrupt to the host |

## Verification
Every implemented rising-edge group is swept one bit at a time, with only that group unmasked. This separates a wrong bit position from a wrong group index or a wrong summary byte. Clearing reads are repeated to catch a latch that refires on a held level. The falling-edge partners are checked on the release of each swept bit, and their own inputs are driven to show they are ignored. Separate patterns cover:
- full and partial masking, which tells latching apart from reporting;
- an edge during a clearing read;
- writes to read-only offsets;
- the missing group, other banks and undecoded offsets.

// File: rtl/hier_irq_pkg.sv
package hier_irq_pkg;
   localparam int GRP_W = 8;
   typedef logic [GRP_W-1:0] grp_byte_t;

   localparam logic [7:0] OFS_SRC   = 8'h00;
   localparam logic [7:0] OFS_LATCH = 8'h20;
   localparam logic [7:0] OFS_MASK  = 8'h40;
   localparam logic [7:0] OFS_HIER  = 8'h60;
   localparam int REGION_SPAN = 32;

   // Group g records falling edges of group g-2 when that group is flagged.
   function automatic bit is_fall_target(input logic [63:0] fall_src, input int g);
      if (g < 2) return 1'b0;
      return fall_src[g-2];
   endfunction
endpackage

// File: rtl/hier_irq_group.sv
module hier_irq_group
   import hier_irq_pkg::*;
#(
   parameter int W         = GRP_W,
   parameter bit FALL_MODE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src_i,
   input  logic         clr_i,
   input  logic         mask_we_i,
   input  logic [W-1:0] mask_d_i,
   output logic [W-1:0] latch_o,
   output logic [W-1:0] mask_o,
   output logic         pend_o
);
   logic [W-1:0] src_q;
   logic [W-1:0] edge_w;
   logic [W-1:0] latch_q;
   logic [W-1:0] mask_q;

   generate
      if (FALL_MODE) begin : g_fall
         assign edge_w = src_q & ~src_i;
      end else begin : g_rise
         assign edge_w = src_i & ~src_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q   <= '0;
         latch_q <= '0;
         mask_q  <= '1;
      end else begin
         src_q   <= src_i;
         latch_q <= (clr_i ? '0 : latch_q) | edge_w;
         if (mask_we_i) mask_q <= mask_d_i;
      end
   end

   assign latch_o = latch_q;
   assign mask_o  = mask_q;
   assign pend_o  = |(latch_q & ~mask_q);
endmodule

// File: rtl/hier_irq_summary.sv
module hier_irq_summary #(
   parameter int NUM_GROUPS = 24,
   parameter int HIER_REGS  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_GROUPS-1:0]    pend_i,
   output logic [HIER_REGS*8-1:0]   hier_o,
   output logic                     irq_o
);
   localparam int SLOTS = HIER_REGS * 8;
   logic irq_q;

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         if (s < NUM_GROUPS) begin : g_live
            assign hier_o[s] = pend_i[s];
         end else begin : g_idle
            assign hier_o[s] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |hier_o;
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/hier_irq_ctrl.sv
module hier_irq_ctrl
   import hier_irq_pkg::*;
#(
   parameter int          NUM_GROUPS    = 24,
   parameter int          HIER_REGS     = 3,
   parameter logic [7:0]  BANK          = 8'h0E,
   parameter logic [63:0] GROUP_PRESENT = 64'h0000_0000_00FF_FFDF,
   parameter logic [63:0] FALL_SRC      = 64'h0000_0000_0000_00C0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_GROUPS*GRP_W-1:0] evt_src,
   input  logic [15:0]                 host_addr,
   input  logic [7:0]                  host_wdata,
   input  logic                        host_wr,
   input  logic                        host_rd,
   output logic [7:0]                  host_rdata,
   output logic                        irq_out
);
   localparam int SLOTS = HIER_REGS * 8;

   generate
      if (NUM_GROUPS < 1 || NUM_GROUPS > REGION_SPAN) begin : g_bad_groups
         $error("NUM_GROUPS must lie in 1..32");
      end
      if (SLOTS < NUM_GROUPS || HIER_REGS > REGION_SPAN) begin : g_bad_hier
         $error("HIER_REGS too small or too large for NUM_GROUPS");
      end
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk_fall
         if (FALL_SRC[g] && ((g + 2 >= NUM_GROUPS) || !GROUP_PRESENT[g] || !GROUP_PRESENT[g+2]))
         begin : g_bad_fall
            $error("falling-edge partner out of range or absent");
         end
      end
   endgenerate

   logic       bank_hit;
   logic [7:0] ofs;
   assign bank_hit = (host_addr[15:8] == BANK);
   assign ofs      = host_addr[7:0];

   logic [NUM_GROUPS-1:0][GRP_W-1:0] src_arr;
   logic [NUM_GROUPS-1:0][GRP_W-1:0] latch_arr;
   logic [NUM_GROUPS-1:0][GRP_W-1:0] mask_arr;
   logic [NUM_GROUPS-1:0]            pend;
   logic [HIER_REGS-1:0][7:0]        hier_arr;

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         if (GROUP_PRESENT[g]) begin : g_on
            localparam bit FALL_T = is_fall_target(FALL_SRC, g);
            logic [GRP_W-1:0] grp_in;
            logic             clr_w, mwe_w;
            if (FALL_T) begin : g_from_low
               assign grp_in = evt_src[(g-2)*GRP_W +: GRP_W];
            end else begin : g_own
               assign grp_in = evt_src[g*GRP_W +: GRP_W];
            end
            assign clr_w = host_rd & bank_hit & (ofs == OFS_LATCH + 8'(g));
            assign mwe_w = host_wr & bank_hit & (ofs == OFS_MASK + 8'(g));
            hier_irq_group #(.W(GRP_W), .FALL_MODE(FALL_T)) u_grp (
               .clk      (clk),
               .rst_n    (rst_n),
               .src_i    (grp_in),
               .clr_i    (clr_w),
               .mask_we_i(mwe_w),
               .mask_d_i (host_wdata),
               .latch_o  (latch_arr[g]),
               .mask_o   (mask_arr[g]),
               .pend_o   (pend[g])
            );
            assign src_arr[g] = grp_in;
         end else begin : g_off
            assign src_arr[g]   = '0;
            assign latch_arr[g] = '0;
            assign mask_arr[g]  = '0;
            assign pend[g]      = 1'b0;
         end
      end
   endgenerate

   hier_irq_summary #(.NUM_GROUPS(NUM_GROUPS), .HIER_REGS(HIER_REGS)) u_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .pend_i(pend),
      .hier_o(hier_arr),
      .irq_o (irq_out)
   );

   logic [7:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (bank_hit) begin
         for (int g = 0; g < NUM_GROUPS; g++) begin
            if (ofs == OFS_SRC   + 8'(g)) rd_mux = src_arr[g];
            if (ofs == OFS_LATCH + 8'(g)) rd_mux = latch_arr[g];
            if (ofs == OFS_MASK  + 8'(g)) rd_mux = mask_arr[g];
         end
         for (int h = 0; h < HIER_REGS; h++) begin
            if (ofs == OFS_HIER + 8'(h)) rd_mux = hier_arr[h];
         end
      end
   end

   logic [7:0] rdata_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q <= '0;
      else if (host_rd) rdata_q <= rd_mux;
   end
   assign host_rdata = rdata_q;
endmodule

// File: rtl/hier_irq_chk.sv
module hier_irq_chk #(
   parameter int         NUM_GROUPS = 24,
   parameter logic [7:0] BANK       = 8'h0E,
   parameter bit         G0_LIVE    = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [15:0]           host_addr,
   input logic [7:0]            host_wdata,
   input logic                  host_wr,
   input logic                  host_rd,
   input logic [7:0]            host_rdata,
   input logic                  irq_out,
   input logic [7:0]            evt0,
   input logic [7:0]            latch0,
   input logic [7:0]            mask0,
   input logic [NUM_GROUPS-1:0] pend
);
   p_irq_follows_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == $past(|pend));

   p_offbank_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr[15:8] != BANK) |=> host_rdata == 8'h00);

   generate
      if (G0_LIVE) begin : g_g0
         p_latch_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (host_rd && host_addr == {BANK, 8'h20} && evt0 == 8'h00) |=> latch0 == 8'h00);

         p_latch_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(host_rd && host_addr == {BANK, 8'h20}) |=> (latch0 & $past(latch0)) == $past(latch0));

         p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && host_addr == {BANK, 8'h40}) |=> mask0 == $past(host_wdata));

         p_full_mask_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mask0 == 8'hFF) |-> !pend[0]);
      end
   endgenerate
endmodule

bind hier_irq_ctrl hier_irq_chk #(
   .NUM_GROUPS(NUM_GROUPS),
   .BANK      (BANK),
   .G0_LIVE   (GROUP_PRESENT[0])
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_addr (host_addr),
   .host_wdata(host_wdata),
   .host_wr   (host_wr),
   .host_rd   (host_rd),
   .host_rdata(host_rdata),
   .irq_out   (irq_out),
   .evt0      (evt_src[7:0]),
   .latch0    (latch_arr[0]),
   .mask0     (mask_arr[0]),
   .pend      (pend)
);

// File: tb/hier_irq_ctrl_tb.sv
module hier_irq_ctrl_tb_top;
   localparam int NG = 24;
   localparam logic [7:0] BK = 8'h0E;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NG*8-1:0] evt_src = '0;
   logic [15:0]   host_addr = '0;
   logic [7:0]    host_wdata = '0;
   logic          host_wr = 1'b0;
   logic          host_rd = 1'b0;
   logic [7:0]    host_rdata;
   logic          irq_out;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   hier_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .evt_src(evt_src),
      .host_addr(host_addr), .host_wdata(host_wdata),
      .host_wr(host_wr), .host_rd(host_rd),
      .host_rdata(host_rdata), .irq_out(irq_out)
   );

   function automatic bit present(input int g);
      return g != 5;
   endfunction
   function automatic bit fall_tgt(input int g);
      return g == 8 || g == 9;
   endfunction
   function automatic bit fall_src(input int g);
      return g == 6 || g == 7;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] ofs, output logic [7:0] d, input logic [7:0] bank = BK);
      @(negedge clk);
      host_addr = {bank, ofs};
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata;
   endtask

   task automatic wr(input logic [7:0] ofs, input logic [7:0] v);
      @(negedge clk);
      host_addr = {BK, ofs};
      host_wdata = v;
      host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] d;
      ticks(4);
      rst_n = 1'b1;
      ticks(1);

      // R1 reset state
      chk("R1 irq", {7'd0, irq_out}, 8'h00);
      for (int g = 0; g < NG; g++) begin
         rd(8'h40 + 8'(g), d);
         chk("R1 mask", d, present(g) ? 8'hFF : 8'h00);
         rd(8'h20 + 8'(g), d);
         chk("R1 latch", d, 8'h00);
      end
      for (int h = 0; h < 3; h++) begin
         rd(8'h60 + 8'(h), d);
         chk("R1 hier", d, 8'h00);
      end

      // R3 R4 R6 R7 R8 sweep over every rising-edge group and bit
      for (int g = 0; g < NG; g++) begin
         if (!present(g) || fall_tgt(g)) continue;
         wr(8'h40 + 8'(g), 8'h00);
         for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            evt_src[g*8+b] = 1'b1;
            @(negedge clk);
            chk("R7 irq not yet", {7'd0, irq_out}, 8'h00);
            @(negedge clk);
            chk("R7 irq raised", {7'd0, irq_out}, 8'h01);
            rd(8'h60 + 8'(g/8), d);
            chk("R6 hier bit", d, 8'(1 << (g % 8)));
            rd(8'h20 + 8'(g), d);
            chk("R3 latch bit", d, 8'(1 << b));
            rd(8'h20 + 8'(g), d);
            chk("R4 cleared, R3 held level", d, 8'h00);
            ticks(1);
            chk("R7 irq dropped", {7'd0, irq_out}, 8'h00);
            evt_src[g*8+b] = 1'b0;
            ticks(1);
            if (fall_src(g)) begin
               rd(8'h20 + 8'(g + 2), d);
               chk("R8 falling latch", d, 8'(1 << b));
            end
         end
         wr(8'h40 + 8'(g), 8'hFF);
      end

      // R5 masking
      @(negedge clk); evt_src[3*8+2] = 1'b1;
      ticks(3);
      chk("R5 masked irq", {7'd0, irq_out}, 8'h00);
      rd(8'h60, d); chk("R5 masked hier", d, 8'h00);
      rd(8'h23, d); chk("R5 masked latch records", d, 8'h04);
      evt_src[3*8+2] = 1'b0;
      wr(8'h43, 8'hFB);
      rd(8'h43, d); chk("R5 mask readback", d, 8'hFB);
      @(negedge clk); evt_src[3*8+3] = 1'b1;
      ticks(3);
      chk("R5 partial mask blocks", {7'd0, irq_out}, 8'h00);
      rd(8'h23, d); chk("R5 partial latch", d, 8'h08);
      @(negedge clk); evt_src[3*8+2] = 1'b1;
      ticks(2);
      chk("R5 open bit passes", {7'd0, irq_out}, 8'h01);
      rd(8'h23, d); chk("R5 open latch", d, 8'h04);
      evt_src[3*8+3:3*8+2] = 2'b00;
      wr(8'h43, 8'hFF);

      // R4 edge during clearing read
      wr(8'h40, 8'h00);
      @(negedge clk); evt_src[0] = 1'b1;
      ticks(2);
      @(negedge clk);
      host_addr = {BK, 8'h20}; host_rd = 1'b1; evt_src[1] = 1'b1;
      @(negedge clk);
      host_rd = 1'b0; d = host_rdata;
      chk("R4 read during edge", d, 8'h01);
      chk("R4 irq kept", {7'd0, irq_out}, 8'h01);
      rd(8'h20, d); chk("R4 edge kept", d, 8'h02);
      evt_src[1:0] = 2'b00;

      // R10 writes to read-only offsets; R6 summary read has no side effect
      wr(8'h41, 8'h00);
      @(negedge clk); evt_src[8] = 1'b1;
      ticks(2);
      wr(8'h21, 8'h00);
      wr(8'h01, 8'hFF);
      wr(8'h60, 8'h00);
      rd(8'h60, d); chk("R10 hier after write", d, 8'h02);
      rd(8'h60, d); chk("R6 hier reread", d, 8'h02);
      rd(8'h01, d); chk("R2 R10 source view", d, 8'h01);
      rd(8'h21, d); chk("R10 latch after write", d, 8'h01);
      evt_src[8] = 1'b0;
      wr(8'h40, 8'hFF);
      wr(8'h41, 8'hFF);

      // R9 missing group
      wr(8'h45, 8'h00);
      rd(8'h45, d); chk("R9 mask write ignored", d, 8'h00);
      @(negedge clk); evt_src[5*8] = 1'b1;
      ticks(3);
      chk("R9 no irq", {7'd0, irq_out}, 8'h00);
      rd(8'h25, d); chk("R9 latch zero", d, 8'h00);
      rd(8'h05, d); chk("R9 source zero", d, 8'h00);
      rd(8'h60, d); chk("R9 hier zero", d, 8'h00);
      evt_src[5*8] = 1'b0;

      // R8 own inputs of a falling-edge group ignored
      wr(8'h48, 8'h00);
      @(negedge clk); evt_src[8*8] = 1'b1;
      ticks(2);
      evt_src[8*8] = 1'b0;
      ticks(2);
      chk("R8 own input no irq", {7'd0, irq_out}, 8'h00);
      @(negedge clk); evt_src[8*8+3] = 1'b1;
      rd(8'h08, d); chk("R8 source shows lower group", d, 8'h00);
      rd(8'h28, d); chk("R8 own input not latched", d, 8'h00);
      evt_src[8*8+3] = 1'b0;
      wr(8'h48, 8'hFF);

      // R2 R11 decode edges
      rd(8'h40, d, 8'h0F); chk("R2 other bank", d, 8'h00);
      rd(8'h70, d); chk("R11 undecoded offset", d, 8'h00);
      rd(8'h63, d); chk("R11 summary beyond count", d, 8'h00);
      rd(8'h58, d); chk("R11 mask beyond groups", d, 8'h00);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule